// File: doc/BRIEF.md
# AXI-Lite Address-Decoding Demultiplexer

This block connects one AXI-Lite manager to a parameterised number of subordinate ports. Each subordinate owns an address region. The region is given by a base address from a parameter array and by a shared count of low address bits that play no part in the match. An incoming read or write address is compared against every region, and the matching port receives the request. The block then carries that port's data and response channels back to the manager.

The read and write sides run as two separate machines, so a read can complete while a write is still in progress. Each side accepts one transaction at a time. It keeps the chosen port connected until the response handshake for that transaction finishes, and only then takes a new address. When an address falls outside every region, the block answers the request itself. It accepts the address (and on a write, the data), then returns a decode-error response. The manager therefore always sees a complete handshake and never stalls.

Top module: `axil_demux`

## Requirements
- R1: While reset is held and after it is released, with no request pending, m_rvalid_o, m_bvalid_o, m_arready_o, m_awready_o and every subordinate VALID output are low.
- R2: A read whose address lies in port i's region raises s_arvalid_o only on bit i. The manager then receives that port's RDATA and RRESP unchanged, and s_rready_o is driven only on bit i.
- R3: A write whose address lies in port i's region raises s_awvalid_o and s_wvalid_o only on bit i. The manager then receives that port's BRESP unchanged, and s_bready_o is driven only on bit i.
- R4: A read to an unmapped address is accepted at once and no subordinate sees it. It is answered with RRESP 2'b11 and RDATA zero, and m_rvalid_o stays high until m_rready_i.
- R5: A write to an unmapped address has its AW and W handshakes accepted and reaches no subordinate. It is answered with BRESP 2'b11.
- R6: Only the address bits above IGNORE_BITS (12 by default) are compared. With the default bases 0x1000, 0x4000, 0x5000 and 0x8000 for ports 0 to 3, address 0x1FFC hits port 0, 0x2000 is unmapped and 0x5FFF hits port 2.
- R7: After an AR handshake, m_arready_o stays low and no AR is forwarded until the R handshake completes.
- R8: After an AW handshake, m_awready_o stays low and no AW is forwarded until the B handshake completes. W is accepted only after AW.
- R9: Only the selected port's READY and response VALID are passed to the manager. The same signals from ports that are not selected have no effect.
- R10: The read and write sides are independent: a full read completes while a write waits for its W data, and the write then finishes on its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_awvalid_i | input | 1 | Manager write address valid |
| m_awready_o | output | 1 | Manager write address ready |
| m_awaddr_i | input | ADDR_W | Manager write address |
| m_wvalid_i | input | 1 | Manager write data valid |
| m_wready_o | output | 1 | Manager write data ready |
| m_wdata_i | input | DATA_W | Manager write data |
| m_wstrb_i | input | DATA_W/8 | Manager write strobes |
| m_bvalid_o | output | 1 | Manager write response valid |
| m_bready_i | input | 1 | Manager write response ready |
| m_bresp_o | output | 2 | Manager write response code |
| m_arvalid_i | input | 1 | Manager read address valid |
| m_arready_o | output | 1 | Manager read address ready |
| m_araddr_i | input | ADDR_W | Manager read address |
| m_rvalid_o | output | 1 | Manager read data valid |
| m_rready_i | input | 1 | Manager read data ready |
| m_rdata_o | output | DATA_W | Manager read data |
| m_rresp_o | output | 2 | Manager read response code |
| s_awvalid_o | output | N_PORTS | Per-port write address valid |
| s_awready_i | input | N_PORTS | Per-port write address ready |
| s_awaddr_o | output | ADDR_W | Write address, shared by all ports |
| s_wvalid_o | output | N_PORTS | Per-port write data valid |
| s_wready_i | input | N_PORTS | Per-port write data ready |
| s_wdata_o | output | DATA_W | Write data, shared by all ports |
| s_wstrb_o | output | DATA_W/8 | Write strobes, shared by all ports |
| s_bvalid_i | input | N_PORTS | Per-port write response valid |
| s_bready_o | output | N_PORTS | Per-port write response ready |
| s_bresp_i | input | 2*N_PORTS | Per-port write response codes, port i at bits 2i+1:2i |
| s_arvalid_o | output | N_PORTS | Per-port read address valid |
| s_arready_i | input | N_PORTS | Per-port read address ready |
| s_araddr_o | output | ADDR_W | Read address, shared by all ports |
| s_rvalid_i | input | N_PORTS | Per-port read data valid |
| s_rready_o | output | N_PORTS | Per-port read data ready |
| s_rdata_i | input | DATA_W*N_PORTS | Per-port read data, port i at bits DATA_W*i upward |
| s_rresp_i | input | 2*N_PORTS | Per-port read response codes, port i at bits 2i+1:2i |

## Verification
Reads and writes are sent to the base of every port. Each port returns a different data word and port 3 returns a slave-error code, so a routing mistake or a dropped response code shows up in the value the manager receives. During each handshake the ports that are not selected hold their READY and VALID high while the selected port is still low. This separates true per-port muxing from a plain OR of all ports. Addresses just inside and just outside a region check which bits take part in the compare. A read run in the middle of a pending write shows that the two sides keep separate state.

// File: rtl/axil_demux_pkg.sv
package axil_demux_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_RESP} wr_state_e;
endpackage

// File: rtl/axil_demux_decode.sv
module axil_demux_decode #(
  parameter int N_PORTS     = 4,
  parameter int ADDR_W      = 32,
  parameter int IGNORE_BITS = 12,
  parameter logic [N_PORTS*ADDR_W-1:0] BASE_ADDRS = '0,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N_PORTS-1:0] match;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] BASE_G = BASE_ADDRS[g*ADDR_W +: ADDR_W];
    assign match[g] = (addr_i >> IGNORE_BITS) == (BASE_G >> IGNORE_BITS);
  end

  // lowest index wins on overlap
  always_comb begin
    idx_o = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/axil_demux_rd.sv
module axil_demux_rd
  import axil_demux_pkg::*;
#(
  parameter int N_PORTS     = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IGNORE_BITS = 12,
  parameter logic [N_PORTS*ADDR_W-1:0] BASE_ADDRS = '0,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        m_arvalid_i,
  output logic                        m_arready_o,
  input  logic [ADDR_W-1:0]           m_araddr_i,
  output logic                        m_rvalid_o,
  input  logic                        m_rready_i,
  output logic [DATA_W-1:0]           m_rdata_o,
  output logic [1:0]                  m_rresp_o,
  output logic [N_PORTS-1:0]          s_arvalid_o,
  input  logic [N_PORTS-1:0]          s_arready_i,
  output logic [ADDR_W-1:0]           s_araddr_o,
  input  logic [N_PORTS-1:0]          s_rvalid_i,
  output logic [N_PORTS-1:0]          s_rready_o,
  input  logic [N_PORTS*DATA_W-1:0]   s_rdata_i,
  input  logic [N_PORTS*2-1:0]        s_rresp_i
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             busy_q, miss_q;
  logic [IDX_W-1:0] sel_q;

  axil_demux_decode #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .IGNORE_BITS(IGNORE_BITS), .BASE_ADDRS(BASE_ADDRS)
  ) u_dec (
    .addr_i(m_araddr_i), .hit_o(hit), .idx_o(idx)
  );

  assign s_araddr_o = m_araddr_i;

  always_comb begin
    s_arvalid_o = '0;
    s_rready_o  = '0;
    m_arready_o = 1'b0;
    m_rvalid_o  = 1'b0;
    m_rdata_o   = '0;
    m_rresp_o   = RESP_OKAY;
    if (!busy_q) begin
      if (m_arvalid_i) begin
        if (hit) begin
          s_arvalid_o[idx] = 1'b1;
          m_arready_o      = s_arready_i[idx];
        end else begin
          m_arready_o = 1'b1;
        end
      end
    end else if (miss_q) begin
      m_rvalid_o = 1'b1;
      m_rresp_o  = RESP_DECERR;
    end else begin
      m_rvalid_o        = s_rvalid_i[sel_q];
      m_rdata_o         = s_rdata_i[int'(sel_q)*DATA_W +: DATA_W];
      m_rresp_o         = s_rresp_i[int'(sel_q)*2 +: 2];
      s_rready_o[sel_q] = m_rready_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      miss_q <= 1'b0;
      sel_q  <= '0;
    end else if (m_arvalid_i && m_arready_o) begin
      busy_q <= 1'b1;
      miss_q <= !hit;
      sel_q  <= idx;
    end else if (busy_q && m_rvalid_o && m_rready_i) begin
      busy_q <= 1'b0;
    end
  end

  assert_ar_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_arvalid_o));
  assert_one_ar_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_arvalid_i && m_arready_o) |=> !m_arready_o);
  assert_rd_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rvalid_o && !m_rready_i) |=> (!m_arready_o && s_arvalid_o == '0));
  assert_rd_decerr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rvalid_o && m_rresp_o == RESP_DECERR && s_rvalid_i == '0) |-> m_rdata_o == '0);
endmodule

// File: rtl/axil_demux_wr.sv
module axil_demux_wr
  import axil_demux_pkg::*;
#(
  parameter int N_PORTS     = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IGNORE_BITS = 12,
  parameter logic [N_PORTS*ADDR_W-1:0] BASE_ADDRS = '0,
  localparam int IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  m_awvalid_i,
  output logic                  m_awready_o,
  input  logic [ADDR_W-1:0]     m_awaddr_i,
  input  logic                  m_wvalid_i,
  output logic                  m_wready_o,
  input  logic [DATA_W-1:0]     m_wdata_i,
  input  logic [STRB_W-1:0]     m_wstrb_i,
  output logic                  m_bvalid_o,
  input  logic                  m_bready_i,
  output logic [1:0]            m_bresp_o,
  output logic [N_PORTS-1:0]    s_awvalid_o,
  input  logic [N_PORTS-1:0]    s_awready_i,
  output logic [ADDR_W-1:0]     s_awaddr_o,
  output logic [N_PORTS-1:0]    s_wvalid_o,
  input  logic [N_PORTS-1:0]    s_wready_i,
  output logic [DATA_W-1:0]     s_wdata_o,
  output logic [STRB_W-1:0]     s_wstrb_o,
  input  logic [N_PORTS-1:0]    s_bvalid_i,
  output logic [N_PORTS-1:0]    s_bready_o,
  input  logic [N_PORTS*2-1:0]  s_bresp_i
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  wr_state_e        state_q;
  logic             miss_q;
  logic [IDX_W-1:0] sel_q;

  axil_demux_decode #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .IGNORE_BITS(IGNORE_BITS), .BASE_ADDRS(BASE_ADDRS)
  ) u_dec (
    .addr_i(m_awaddr_i), .hit_o(hit), .idx_o(idx)
  );

  assign s_awaddr_o = m_awaddr_i;
  assign s_wdata_o  = m_wdata_i;
  assign s_wstrb_o  = m_wstrb_i;

  always_comb begin
    s_awvalid_o = '0;
    s_wvalid_o  = '0;
    s_bready_o  = '0;
    m_awready_o = 1'b0;
    m_wready_o  = 1'b0;
    m_bvalid_o  = 1'b0;
    m_bresp_o   = RESP_OKAY;
    case (state_q)
      WR_IDLE: begin
        if (m_awvalid_i) begin
          if (hit) begin
            s_awvalid_o[idx] = 1'b1;
            m_awready_o      = s_awready_i[idx];
          end else begin
            m_awready_o = 1'b1;
          end
        end
      end
      WR_DATA: begin
        if (miss_q) begin
          m_wready_o = 1'b1; // sink data locally
        end else begin
          s_wvalid_o[sel_q] = m_wvalid_i;
          m_wready_o        = s_wready_i[sel_q];
        end
      end
      WR_RESP: begin
        if (miss_q) begin
          m_bvalid_o = 1'b1;
          m_bresp_o  = RESP_DECERR;
        end else begin
          m_bvalid_o        = s_bvalid_i[sel_q];
          m_bresp_o         = s_bresp_i[int'(sel_q)*2 +: 2];
          s_bready_o[sel_q] = m_bready_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      miss_q  <= 1'b0;
      sel_q   <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (m_awvalid_i && m_awready_o) begin
          state_q <= WR_DATA;
          miss_q  <= !hit;
          sel_q   <= idx;
        end
        WR_DATA: if (m_wvalid_i && m_wready_o) state_q <= WR_RESP;
        WR_RESP: if (m_bvalid_o && m_bready_i) state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  assert_aw_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_awvalid_o));
  assert_w_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_wvalid_o));
  assert_one_aw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_i && m_awready_o) |=> !m_awready_o);
  assert_wr_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_bvalid_o && !m_bready_i) |=> (!m_awready_o && s_awvalid_o == '0));
  assert_w_after_aw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_i && m_awready_o) |-> !(m_wvalid_i && m_wready_o));
endmodule

// File: rtl/axil_demux.sv
module axil_demux #(
  parameter int N_PORTS     = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IGNORE_BITS = 12,
  parameter logic [N_PORTS*ADDR_W-1:0] BASE_ADDRS =
    {32'h0000_8000, 32'h0000_5000, 32'h0000_4000, 32'h0000_1000},
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        m_awvalid_i,
  output logic                        m_awready_o,
  input  logic [ADDR_W-1:0]           m_awaddr_i,
  input  logic                        m_wvalid_i,
  output logic                        m_wready_o,
  input  logic [DATA_W-1:0]           m_wdata_i,
  input  logic [STRB_W-1:0]           m_wstrb_i,
  output logic                        m_bvalid_o,
  input  logic                        m_bready_i,
  output logic [1:0]                  m_bresp_o,
  input  logic                        m_arvalid_i,
  output logic                        m_arready_o,
  input  logic [ADDR_W-1:0]           m_araddr_i,
  output logic                        m_rvalid_o,
  input  logic                        m_rready_i,
  output logic [DATA_W-1:0]           m_rdata_o,
  output logic [1:0]                  m_rresp_o,
  output logic [N_PORTS-1:0]          s_awvalid_o,
  input  logic [N_PORTS-1:0]          s_awready_i,
  output logic [ADDR_W-1:0]           s_awaddr_o,
  output logic [N_PORTS-1:0]          s_wvalid_o,
  input  logic [N_PORTS-1:0]          s_wready_i,
  output logic [DATA_W-1:0]           s_wdata_o,
  output logic [STRB_W-1:0]           s_wstrb_o,
  input  logic [N_PORTS-1:0]          s_bvalid_i,
  output logic [N_PORTS-1:0]          s_bready_o,
  input  logic [N_PORTS*2-1:0]        s_bresp_i,
  output logic [N_PORTS-1:0]          s_arvalid_o,
  input  logic [N_PORTS-1:0]          s_arready_i,
  output logic [ADDR_W-1:0]           s_araddr_o,
  input  logic [N_PORTS-1:0]          s_rvalid_i,
  output logic [N_PORTS-1:0]          s_rready_o,
  input  logic [N_PORTS*DATA_W-1:0]   s_rdata_i,
  input  logic [N_PORTS*2-1:0]        s_rresp_i
);
  axil_demux_wr #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IGNORE_BITS(IGNORE_BITS), .BASE_ADDRS(BASE_ADDRS)
  ) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .m_awvalid_i(m_awvalid_i), .m_awready_o(m_awready_o), .m_awaddr_i(m_awaddr_i),
    .m_wvalid_i(m_wvalid_i), .m_wready_o(m_wready_o), .m_wdata_i(m_wdata_i),
    .m_wstrb_i(m_wstrb_i), .m_bvalid_o(m_bvalid_o), .m_bready_i(m_bready_i),
    .m_bresp_o(m_bresp_o),
    .s_awvalid_o(s_awvalid_o), .s_awready_i(s_awready_i), .s_awaddr_o(s_awaddr_o),
    .s_wvalid_o(s_wvalid_o), .s_wready_i(s_wready_i), .s_wdata_o(s_wdata_o),
    .s_wstrb_o(s_wstrb_o), .s_bvalid_i(s_bvalid_i), .s_bready_o(s_bready_o),
    .s_bresp_i(s_bresp_i)
  );

  axil_demux_rd #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IGNORE_BITS(IGNORE_BITS), .BASE_ADDRS(BASE_ADDRS)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .m_arvalid_i(m_arvalid_i), .m_arready_o(m_arready_o), .m_araddr_i(m_araddr_i),
    .m_rvalid_o(m_rvalid_o), .m_rready_i(m_rready_i), .m_rdata_o(m_rdata_o),
    .m_rresp_o(m_rresp_o),
    .s_arvalid_o(s_arvalid_o), .s_arready_i(s_arready_i), .s_araddr_o(s_araddr_o),
    .s_rvalid_i(s_rvalid_i), .s_rready_o(s_rready_o), .s_rdata_i(s_rdata_i),
    .s_rresp_i(s_rresp_i)
  );
endmodule

// File: tb/axil_demux_tb.sv
module axil_demux_tb;
  localparam int N = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic m_awvalid_i = 0, m_wvalid_i = 0, m_bready_i = 0, m_arvalid_i = 0, m_rready_i = 0;
  logic [31:0] m_awaddr_i = 0, m_wdata_i = 0, m_araddr_i = 0;
  logic [3:0]  m_wstrb_i = 0;
  logic m_awready_o, m_wready_o, m_bvalid_o, m_arready_o, m_rvalid_o;
  logic [1:0]  m_bresp_o, m_rresp_o;
  logic [31:0] m_rdata_o, s_awaddr_o, s_wdata_o, s_araddr_o;
  logic [3:0]  s_wstrb_o;
  logic [N-1:0] s_awvalid_o, s_wvalid_o, s_bready_o, s_arvalid_o, s_rready_o;
  logic [N-1:0] s_awready_i = 0, s_wready_i = 0, s_bvalid_i = 0, s_arready_i = 0, s_rvalid_i = 0;
  logic [N*32-1:0] s_rdata_i;
  logic [N*2-1:0]  s_rresp_i, s_bresp_i;

  int n_tests = 0;
  int n_fail  = 0;

  axil_demux u_dut (
    .clk_i, .rst_ni,
    .m_awvalid_i, .m_awready_o, .m_awaddr_i, .m_wvalid_i, .m_wready_o, .m_wdata_i,
    .m_wstrb_i, .m_bvalid_o, .m_bready_i, .m_bresp_o,
    .m_arvalid_i, .m_arready_o, .m_araddr_i, .m_rvalid_o, .m_rready_i, .m_rdata_o,
    .m_rresp_o,
    .s_awvalid_o, .s_awready_i, .s_awaddr_o, .s_wvalid_o, .s_wready_i, .s_wdata_o,
    .s_wstrb_o, .s_bvalid_i, .s_bready_o, .s_bresp_i,
    .s_arvalid_o, .s_arready_i, .s_araddr_o, .s_rvalid_i, .s_rready_o, .s_rdata_i,
    .s_rresp_i
  );

  // per-port response fixtures: port j returns data D0D00000+j; port 3 answers SLVERR (2'b10)
  function automatic logic [1:0] resp_of(int j);
    return (j == 3) ? 2'b10 : 2'b00;
  endfunction

  initial begin
    for (int j = 0; j < N; j++) begin
      s_rdata_i[j*32 +: 32] = 32'hD0D0_0000 + j;
      s_rresp_i[j*2 +: 2]   = resp_of(j);
      s_bresp_i[j*2 +: 2]   = resp_of(j);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] bit_of(int i);
    return N'(1) << i;
  endfunction

  task automatic rd_port(input int i, input logic [31:0] addr, input string tag);
    @(negedge clk_i);
    m_arvalid_i = 1; m_araddr_i = addr; s_arready_i = ~bit_of(i);
    #1 chk({tag, " R9 arready from other port"}, m_arready_o, 0);
    chk({tag, " R2 arvalid fanout"}, s_arvalid_o, bit_of(i));
    @(negedge clk_i);
    s_arready_i = '1;
    #1 chk({tag, " R2 arready"}, m_arready_o, 1);
    @(negedge clk_i);
    m_araddr_i = addr ^ 32'h0000_4000; s_arready_i = '1; s_rvalid_i = ~bit_of(i);
    #1 chk("R7 arready while pending", m_arready_o, 0);
    chk("R7 no ar forward while pending", s_arvalid_o, 0);
    chk("R9 rvalid from other port", m_rvalid_o, 0);
    @(negedge clk_i);
    m_arvalid_i = 0; s_arready_i = 0; s_rvalid_i = '1; m_rready_i = 1;
    #1 chk({tag, " R2 rvalid"}, m_rvalid_o, 1);
    chk({tag, " R2 rdata"}, m_rdata_o, 32'hD0D0_0000 + i);
    chk({tag, " R2 rresp"}, m_rresp_o, resp_of(i));
    chk({tag, " R2 rready fanout"}, s_rready_o, bit_of(i));
    @(negedge clk_i);
    s_rvalid_i = 0; m_rready_i = 0;
    #1 chk({tag, " R2 idle after R"}, m_rvalid_o, 0);
  endtask

  task automatic rd_miss(input logic [31:0] addr, input string tag);
    @(negedge clk_i);
    m_arvalid_i = 1; m_araddr_i = addr; s_arready_i = '1;
    #1 chk({tag, " R4 no ar forward"}, s_arvalid_o, 0);
    chk({tag, " R4 arready"}, m_arready_o, 1);
    @(negedge clk_i);
    m_arvalid_i = 0; s_rvalid_i = '1; m_rready_i = 0;
    #1 chk({tag, " R4 rvalid"}, m_rvalid_o, 1);
    chk({tag, " R4 rresp decerr"}, m_rresp_o, 2'b11);
    chk({tag, " R4 rdata zero"}, m_rdata_o, 0);
    chk({tag, " R4 no rready forward"}, s_rready_o, 0);
    @(negedge clk_i);
    m_rready_i = 1;
    #1 chk({tag, " R4 rvalid held"}, m_rvalid_o, 1);
    @(negedge clk_i);
    m_rready_i = 0; s_rvalid_i = 0;
    #1 chk({tag, " R4 done"}, m_rvalid_o, 0);
  endtask

  task automatic wr_port(input int i, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk_i);
    m_awvalid_i = 1; m_awaddr_i = addr; s_awready_i = ~bit_of(i);
    #1 chk("R9 awready from other port", m_awready_o, 0);
    chk("R3 awvalid fanout", s_awvalid_o, bit_of(i));
    @(negedge clk_i);
    s_awready_i = '1;
    #1 chk("R3 awready", m_awready_o, 1);
    @(negedge clk_i);
    m_awaddr_i = addr ^ 32'h0000_4000; m_wvalid_i = 1; m_wdata_i = data; m_wstrb_i = 4'hF;
    s_wready_i = ~bit_of(i);
    #1 chk("R8 awready while pending", m_awready_o, 0);
    chk("R8 no aw forward while pending", s_awvalid_o, 0);
    chk("R3 wvalid fanout", s_wvalid_o, bit_of(i));
    chk("R9 wready from other port", m_wready_o, 0);
    chk("R3 wdata", s_wdata_o, data);
    @(negedge clk_i);
    s_wready_i = '1;
    #1 chk("R3 wready", m_wready_o, 1);
    @(negedge clk_i);
    m_awvalid_i = 0; m_wvalid_i = 0; s_awready_i = 0; s_wready_i = 0;
    s_bvalid_i = ~bit_of(i); m_bready_i = 1;
    #1 chk("R9 bvalid from other port", m_bvalid_o, 0);
    @(negedge clk_i);
    s_bvalid_i = '1;
    #1 chk("R3 bvalid", m_bvalid_o, 1);
    chk("R3 bresp", m_bresp_o, resp_of(i));
    chk("R3 bready fanout", s_bready_o, bit_of(i));
    @(negedge clk_i);
    s_bvalid_i = 0; m_bready_i = 0;
    #1 chk("R3 idle after B", m_bvalid_o, 0);
  endtask

  task automatic wr_miss(input logic [31:0] addr);
    @(negedge clk_i);
    m_awvalid_i = 1; m_awaddr_i = addr; s_awready_i = '1;
    #1 chk("R5 no aw forward", s_awvalid_o, 0);
    chk("R5 awready", m_awready_o, 1);
    @(negedge clk_i);
    m_awvalid_i = 0; s_awready_i = 0; m_wvalid_i = 1; m_wdata_i = 32'h1234_5678;
    s_wready_i = 0;
    #1 chk("R5 wready local", m_wready_o, 1);
    chk("R5 no w forward", s_wvalid_o, 0);
    @(negedge clk_i);
    m_wvalid_i = 0; s_bvalid_i = '1; m_bready_i = 1;
    #1 chk("R5 bvalid", m_bvalid_o, 1);
    chk("R5 bresp decerr", m_bresp_o, 2'b11);
    chk("R5 no bready forward", s_bready_o, 0);
    @(negedge clk_i);
    s_bvalid_i = 0; m_bready_i = 0;
    #1 chk("R5 done", m_bvalid_o, 0);
  endtask

  task automatic reset_test;
    #5 chk("R1 rvalid in reset", m_rvalid_o, 0);
    chk("R1 bvalid in reset", m_bvalid_o, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    #1 chk("R1 arready idle", m_arready_o, 0);
    chk("R1 awready idle", m_awready_o, 0);
    chk("R1 sub valids idle", {s_arvalid_o, s_awvalid_o, s_wvalid_o}, 0);
    chk("R1 rvalid idle", m_rvalid_o, 0);
  endtask

  task automatic mixed_test;
    // R10: write held in data phase while a read completes
    @(negedge clk_i);
    m_awvalid_i = 1; m_awaddr_i = 32'h0000_4010; s_awready_i = '1;
    @(negedge clk_i);
    m_awvalid_i = 0; s_awready_i = 0;
    rd_port(2, 32'h0000_5020, "R10 read");
    #1 chk("R10 no bvalid during read", m_bvalid_o, 0);
    @(negedge clk_i);
    m_wvalid_i = 1; m_wdata_i = 32'hCAFE_0001; s_wready_i = '1;
    #1 chk("R10 write resumes on port1", s_wvalid_o, bit_of(1));
    chk("R10 wready", m_wready_o, 1);
    @(negedge clk_i);
    m_wvalid_i = 0; s_wready_i = 0; s_bvalid_i = bit_of(1); m_bready_i = 1;
    #1 chk("R10 bvalid", m_bvalid_o, 1);
    @(negedge clk_i);
    s_bvalid_i = 0; m_bready_i = 0;
    #1 chk("R10 write done", m_bvalid_o, 0);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    reset_test();
    rd_port(0, 32'h0000_1000, "R2 p0");
    rd_port(1, 32'h0000_4000, "R2 p1");
    rd_port(2, 32'h0000_5000, "R2 p2");
    rd_port(3, 32'h0000_8000, "R2 p3");
    for (int i = 0; i < N; i++) begin
      logic [31:0] base;
      case (i)
        0: base = 32'h0000_1000;
        1: base = 32'h0000_4000;
        2: base = 32'h0000_5000;
        default: base = 32'h0000_8000;
      endcase
      wr_port(i, base, 32'hBEEF_0000 + i);
    end
    rd_miss(32'h0002_0000, "R4 far");
    wr_miss(32'h0000_0000);
    rd_port(0, 32'h0000_1FFC, "R6 top of p0");
    rd_miss(32'h0000_2000, "R6 just past p0");
    rd_port(2, 32'h0000_5FFF, "R6 top of p2");
    mixed_test();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule